// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory, one after the other. The virtual address is cut into three fields: a 12-bit top index (bits 31:20), a 10-bit middle index (bits 19:10) and a 10-bit byte offset (bits 9:0), which matches a 1 KiB page. The top index picks an entry in the directory table whose byte address is given by the root input. That entry names the base of a leaf table. The middle index then picks an entry in the leaf table, and that entry holds the frame of the physical page.

A client offers one request at a time on a valid/ready handshake. The walker issues each table read on a single-beat read port. It holds the read until memory answers, then presents either the translated address or a fault that says which level held an invalid entry. The result stays on the outputs until the client acknowledges it. Every table entry is 32 bits wide. Bit 0 is the valid flag and bits 31:10 carry a page-aligned base. The walker ignores bits 9:1.

The walker runs five states. In IDLE it waits for a request. In FETCH_DIR it waits for the directory entry. In FETCH_LEAF it waits for the leaf entry. DONE holds a successful result and FAULT holds a failed one. The transitions are:
- accept: IDLE to FETCH_DIR, when req_valid is high.
- dir_ok: FETCH_DIR to FETCH_LEAF, on a response whose valid bit is 1.
- dir_bad: FETCH_DIR to FAULT, on a response whose valid bit is 0.
- leaf_ok: FETCH_LEAF to DONE, on a response whose valid bit is 1.
- leaf_bad: FETCH_LEAF to FAULT, on a response whose valid bit is 0.
- release: DONE or FAULT to IDLE, on rsp_ack.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_req_valid are both 0.
- R2: A request is taken only while req_ready is 1. A req_valid or req_vaddr change during a walk has no effect on the result of the walk in progress.
- R3: The first read after a request is accepted goes to root + 4·vaddr[31:20], with 32-bit wrap. The root is the value of root_base in the accepting cycle, and later changes of root_base do not affect the walk.
- R4: After a valid directory entry E, the second read goes to {E[31:10], 10'b0} + 4·vaddr[19:10], with 32-bit wrap.
- R5: mem_req_valid stays 1 and mem_req_addr stays stable from the start of a read until the cycle in which mem_rsp_valid is 1. A response in the first cycle of a read is allowed.
- R6: When the leaf entry L is valid, the result has rsp_fault = 0 and rsp_paddr = {L[31:10], vaddr[9:0]}.
- R7: A directory entry with bit 0 = 0 ends the walk with rsp_fault = 1, rsp_fault_lvl = 0 and rsp_paddr = 0. No second read is issued.
- R8: A leaf entry with bit 0 = 0 ends the walk with rsp_fault = 1, rsp_fault_lvl = 1 and rsp_paddr = 0.
- R9: The result appears in the cycle after the final memory response. It is held unchanged while rsp_ack is 0. One cycle after rsp_ack, rsp_valid is 0 and req_ready is 1.
- R10: A mem_rsp_valid that arrives while no read is pending is ignored. It changes neither a held result nor the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the directory table |
| mem_req_valid | output | 1 | Table read pending |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result held |
| rsp_ack | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 directory, 1 leaf |

## Verification
Two cases are the hardest to reach from the ports. The first is a leaf-level fault, which needs a valid directory entry that points to a table whose selected slot is invalid. The second is a read answered in its very first cycle while the client is pushing other requests and the root is changing. The bench memory derives every entry arithmetically from a hash of its address. As a result, the sweep over the top and middle indices lands on invalid entries at both levels at a predictable rate, and the bench can still compute each expected entry on its own. The response latency cycles through 0 to 3 across the sweep. Stray requests, root changes and unsolicited responses are injected while reads and results are pending.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_DIR,
        ST_FETCH_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    // Entries are four bytes, so an index is scaled by a shift of two.
    localparam int unsigned ENTRY_SHIFT = 2;

    localparam logic LVL_DIR  = 1'b0;
    localparam logic LVL_LEAF = 1'b1;

endpackage

// File: rtl/ptw_va_fields.sv
module ptw_va_fields #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned TOP_W = 12,
    parameter int unsigned MID_W = 10,
    parameter int unsigned OFF_W = 10
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [TOP_W-1:0] top_idx,
    output logic [MID_W-1:0] mid_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned MID_LO = OFF_W;
    localparam int unsigned TOP_LO = OFF_W + MID_W;

    always_comb begin
        offset  = vaddr[OFF_W-1:0];
        mid_idx = vaddr[MID_LO +: MID_W];
        top_idx = vaddr[TOP_LO +: TOP_W];
    end

    initial begin
        if (TOP_W + MID_W + OFF_W != VA_W) begin
            $error("field widths do not add up to the address width");
        end
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned IDX_W = 12
) (
    input  logic [AW-1:0]    table_base,
    input  logic [IDX_W-1:0] index,
    output logic [AW-1:0]    entry_addr
);
    localparam int unsigned PAD_W = AW - IDX_W - ENTRY_SHIFT;

    logic [AW-1:0] byte_off;

    always_comb begin
        byte_off   = {{PAD_W{1'b0}}, index, {ENTRY_SHIFT{1'b0}}};
        entry_addr = table_base + byte_off;
    end
endmodule

// File: rtl/ptw_entry_fields.sv
module ptw_entry_fields #(
    parameter int unsigned AW    = 32,
    parameter int unsigned OFF_W = 10
) (
    input  logic [AW-1:0] entry,
    output logic          entry_valid,
    output logic [AW-1:0] entry_page
);
    logic unused_rsvd;

    always_comb begin
        entry_valid = entry[0];
        entry_page  = {entry[AW-1:OFF_W], {OFF_W{1'b0}}};
        unused_rsvd = ^entry[OFF_W-1:1];
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_vaddr,
    input  logic [AW-1:0]    root_base,
    input  logic [AW-1:0]    dir_entry_addr,
    input  logic [AW-1:0]    leaf_entry_addr,
    input  logic [OFF_W-1:0] offset,
    input  logic             mem_rsp_valid,
    input  logic             entry_valid,
    input  logic [AW-1:0]    entry_page,
    input  logic             rsp_ack,
    output logic [AW-1:0]    vaddr_q,
    output logic [AW-1:0]    root_q,
    output logic [AW-1:0]    leaf_base_q,
    output logic             req_ready,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_fault_lvl
);
    walk_state_e state, state_nx;
    logic [AW-1:0] frame_q;
    logic          lvl_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nx = ST_FETCH_DIR;
            end
            ST_FETCH_DIR: begin
                if (mem_rsp_valid) state_nx = entry_valid ? ST_FETCH_LEAF : ST_FAULT;
            end
            ST_FETCH_LEAF: begin
                if (mem_rsp_valid) state_nx = entry_valid ? ST_DONE : ST_FAULT;
            end
            ST_DONE, ST_FAULT: begin
                if (rsp_ack) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Walk context captured along the way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            root_q      <= '0;
            leaf_base_q <= '0;
            frame_q     <= '0;
            lvl_q       <= LVL_DIR;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                root_q  <= root_base;
            end
            if (state == ST_FETCH_DIR && mem_rsp_valid) begin
                if (entry_valid) leaf_base_q <= entry_page;
                else             lvl_q       <= LVL_DIR;
            end
            if (state == ST_FETCH_LEAF && mem_rsp_valid) begin
                if (entry_valid) frame_q <= entry_page;
                else             lvl_q   <= LVL_LEAF;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        rsp_valid     = 1'b0;
        rsp_paddr     = '0;
        rsp_fault     = 1'b0;
        rsp_fault_lvl = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_FETCH_DIR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_entry_addr;
            end
            ST_FETCH_LEAF: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = leaf_entry_addr;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_paddr = {frame_q[AW-1:OFF_W], offset};
            end
            ST_FAULT: begin
                rsp_valid     = 1'b1;
                rsp_fault     = 1'b1;
                rsp_fault_lvl = lvl_q;
            end
            default: ;
        endcase
    end

    // R2
    idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R3
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (mem_req_valid && !req_ready));

    // R5
    read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_DIR && mem_rsp_valid && !entry_valid)
        |=> (rsp_valid && rsp_fault && !rsp_fault_lvl && !mem_req_valid));

    // R8
    leaf_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_LEAF && mem_rsp_valid && !entry_valid)
        |=> (rsp_valid && rsp_fault && rsp_fault_lvl));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack)
        |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |=> (req_ready && !rsp_valid));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned TOP_W = 12,
    parameter int unsigned MID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] root_base,
    output logic            mem_req_valid,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ack,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            rsp_fault_lvl
);
    localparam int unsigned OFF_W = VA_W - TOP_W - MID_W;

    logic [VA_W-1:0]  vaddr_q, root_q, leaf_base_q;
    logic [TOP_W-1:0] top_idx;
    logic [MID_W-1:0] mid_idx;
    logic [OFF_W-1:0] offset;
    logic [VA_W-1:0]  dir_entry_addr, leaf_entry_addr, entry_page;
    logic             entry_valid;

    ptw_va_fields #(.VA_W(VA_W), .TOP_W(TOP_W), .MID_W(MID_W), .OFF_W(OFF_W)) u_fields (
        .vaddr   (vaddr_q),
        .top_idx (top_idx),
        .mid_idx (mid_idx),
        .offset  (offset)
    );

    ptw_entry_addr #(.AW(VA_W), .IDX_W(TOP_W)) u_dir_addr (
        .table_base (root_q),
        .index      (top_idx),
        .entry_addr (dir_entry_addr)
    );

    ptw_entry_addr #(.AW(VA_W), .IDX_W(MID_W)) u_leaf_addr (
        .table_base (leaf_base_q),
        .index      (mid_idx),
        .entry_addr (leaf_entry_addr)
    );

    ptw_entry_fields #(.AW(VA_W), .OFF_W(OFF_W)) u_entry (
        .entry       (mem_rsp_data),
        .entry_valid (entry_valid),
        .entry_page  (entry_page)
    );

    ptw_fsm #(.AW(VA_W), .OFF_W(OFF_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_vaddr       (req_vaddr),
        .root_base       (root_base),
        .dir_entry_addr  (dir_entry_addr),
        .leaf_entry_addr (leaf_entry_addr),
        .offset          (offset),
        .mem_rsp_valid   (mem_rsp_valid),
        .entry_valid     (entry_valid),
        .entry_page      (entry_page),
        .rsp_ack         (rsp_ack),
        .vaddr_q         (vaddr_q),
        .root_q          (root_q),
        .leaf_base_q     (leaf_base_q),
        .req_ready       (req_ready),
        .mem_req_valid   (mem_req_valid),
        .mem_req_addr    (mem_req_addr),
        .rsp_valid       (rsp_valid),
        .rsp_paddr       (rsp_paddr),
        .rsp_fault       (rsp_fault),
        .rsp_fault_lvl   (rsp_fault_lvl)
    );
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;

    int checks = 0;
    int errors = 0;
    int walks  = 0;

    ptw_walker i_ptw_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .root_base     (root_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ack       (rsp_ack),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory contents are a hash of the entry address: about one slot in
    // eight is invalid, the rest carry a pseudo-random page base.
    function automatic logic [31:0] entry_at(input logic [31:0] addr);
        logic [31:0] h;
        h = addr * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        return {h[31:10], 9'd0, (h[7:5] != 3'b000)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Waits out one table read of the given latency, then answers it.
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                         input int lat, input string tag, input logic disturb,
                         input logic [31:0] va);
        for (int k = 0; k < lat; k++) begin
            check("R5", {31'd0, mem_req_valid}, 32'd1);
            check(tag, mem_req_addr, exp_addr);
            if (disturb) begin
                req_valid = 1'b1;
                req_vaddr = ~va;
                root_base = root_base ^ 32'h0F0F_F000;
            end
            tick();
        end
        req_valid = 1'b0;
        check("R5", {31'd0, mem_req_valid}, 32'd1);
        check(tag, mem_req_addr, exp_addr);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        tick();
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    task automatic walk(input logic [11:0] t, input logic [9:0] m, input logic [9:0] off,
                        input logic [31:0] root, input int lat);
        logic [31:0] va, daddr, dent, laddr, lent, exp_pa;
        logic        exp_fault, exp_lvl;
        va    = {t, m, off};
        daddr = root + {18'd0, t, 2'b00};
        dent  = entry_at(daddr);
        laddr = {dent[31:10], 10'd0} + {20'd0, m, 2'b00};
        lent  = entry_at(laddr);
        walks++;

        check("R2", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = root;
        tick();
        req_valid = 1'b0;

        serve(daddr, dent, lat, "R3", 1'b1, va);
        if (!dent[0]) begin
            exp_fault = 1'b1; exp_lvl = 1'b0; exp_pa = '0;
            check("R7", {31'd0, mem_req_valid}, 32'd0);
            check("R7", {30'd0, rsp_fault, rsp_fault_lvl}, 32'd2);
        end else begin
            serve(laddr, lent, (lat + 1) % 4, "R4", 1'b0, va);
            if (!lent[0]) begin
                exp_fault = 1'b1; exp_lvl = 1'b1; exp_pa = '0;
                check("R8", {30'd0, rsp_fault, rsp_fault_lvl}, 32'd3);
            end else begin
                exp_fault = 1'b0; exp_lvl = 1'b0; exp_pa = {lent[31:10], off};
                check("R6", {31'd0, rsp_fault}, 32'd0);
            end
        end
        check("R9", {31'd0, rsp_valid}, 32'd1);
        check(exp_fault ? "R7/R8 paddr" : "R6", rsp_paddr, exp_pa);

        // Hold without ack while memory sends unsolicited responses.
        for (int h = 0; h < 2; h++) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = ~dent;
            tick();
            mem_rsp_valid = 1'b0;
            check("R10", {30'd0, rsp_valid, mem_req_valid}, 32'd2);
            check("R9", rsp_paddr, exp_pa);
            check("R9", {30'd0, rsp_fault, rsp_fault_lvl}, {30'd0, exp_fault, exp_lvl});
        end

        rsp_ack = 1'b1;
        tick();
        rsp_ack = 1'b0;
        check("R9", {30'd0, rsp_valid, req_ready}, 32'd1);

        // Stray response while idle.
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFF_FC01;
        tick();
        mem_rsp_valid = 1'b0;
        check("R10", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

        for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < 4096; t += 97) begin
                for (int m = 0; m < 1024; m += 101) begin
                    walk(12'(t), 10'(m), 10'((t * 7 + m) % 1024),
                         (r == 0) ? 32'h0004_0000 : 32'hFFFF_F000, (t + m + r) % 4);
                end
            end
        end

        for (int e = 0; e < 8; e++) begin
            walk((e & 1) ? 12'hFFF : 12'h000, (e & 2) ? 10'h3FF : 10'h000,
                 (e & 4) ? 10'h3FF : 10'h000, 32'h0123_4000, e % 4);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule